// File: doc/BRIEF.md
# Interrupt controller command sequencer

This block is the host-facing register front end of one programmable interrupt controller. A host writes and reads bytes through a one-bit address. The block runs the initialization word sequence, decodes the operational command bytes and keeps the mask register, the vector base and the mode flags. It tells a separate priority block what to do through a one-cycle command strobe carrying an opcode and an input number.

The priority search itself lives in that separate block. It feeds back its request and in-service registers and the currently winning input. The sequencer uses these to answer register reads and poll reads.

A byte at address 0 is classed by its bit pattern:
- Bit 4 set starts initialization.
- Bit 4 clear with bit 3 set is an operational control word.
- Both clear makes bits 7:5 an end-of-interrupt or rotate command.

Top module: `irq_cmd_seq`

## Requirements
- R1: Reset clears the mask, the vector base, all mode flags (nested, auto-EOI, rotate-on-auto-EOI, special mask, read-select, poll), read data and the strobe. It also returns the init sequencer to idle, so the next address-1 write loads the mask.
- R2: An address-0 write with bit 4 set clears the mask, special mask and read-select. It issues a strobe with opcode 6 (init, number 0) and records bit 0 as the mode-word flag. When bit 0 is 0 it also clears the nested and auto-EOI flags.
- R3: After a start, the first address-1 write stores data AND 0xF8 as the vector base. The second address-1 write is accepted and discarded. A third address-1 write is taken as the mode word only when the mode-word flag is 1: bit 4 sets nested mode and bit 1 sets auto-EOI. Otherwise the third write already loads the mask.
- R4: With the sequencer idle, an address-1 write loads the mask. The mask does not change in a cycle without a write.
- R5: An address-0 write with bit 4 = 0 and bit 3 = 1 behaves as follows:
  - Bit 2 = 1 arms a poll.
  - Bit 1 = 1 loads read-select from bit 0.
  - Bit 6 = 1 loads special mask from bit 5.
  - A field whose enable bit is 0 is left unchanged.
- R6: On an address-0 write with bits 4:3 = 00, command value 0 in bits 7:5 clears rotate-on-auto-EOI and value 4 sets it. Value 2 issues no strobe and changes no flag.
- R7: Commands on bits 7:5 produce a strobe one cycle after the write:
  - 1 gives opcode 0 (non-specific EOI).
  - 5 gives opcode 1 (rotating non-specific EOI).
  - 3 gives opcode 2 (specific EOI), number from bits 2:0.
  - 7 gives opcode 3 (rotating specific EOI), number from bits 2:0.
  - 6 gives opcode 4 (set priority), number from bits 2:0.
- R8: Read data is registered and valid in the cycle after the read. Address 1 returns the mask. Address 0 returns the in-service input when read-select is 1, and the request input otherwise.
- R9: The first read after a poll is armed returns the winning input number zero-extended and strobes opcode 5 with that number. If no input is pending it returns 7 with no strobe. Either way the poll is disarmed.
- R10: When a write and a read occur in the same cycle, only the write is processed. Read data holds and an armed poll stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| req_bits | input | 8 | Request register from priority block |
| isv_bits | input | 8 | In-service register from priority block |
| pend_valid | input | 1 | Priority block has a winning input |
| pend_num | input | 3 | Number of the winning input |
| mask_o | output | 8 | Mask register |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| nested_o | output | 1 | Special fully nested mode |
| auto_eoi_o | output | 1 | Auto-EOI mode |
| rot_aeoi_o | output | 1 | Rotate on auto-EOI |
| spec_mask_o | output | 1 | Special mask mode |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Command opcode (0..6 as listed) |
| cmd_num | output | 3 | Input number for the command |

## Verification
Every result is registered once, so a write or read presented before clock edge k shows on the outputs right after edge k and no later. This holds for the mask, base, flags, strobe and read data alike. The bench drives each operation on a falling edge, holds it across one rising edge and samples all outputs at the next falling edge. That is exactly one register stage later, with an idle cycle before the next operation. It also confirms that the strobe is absent at that sample whenever a command must have no effect.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
  localparam int DW  = 8;
  localparam int NIN = 8;
  localparam int NW  = $clog2(NIN);

  // address-0 byte classification bits
  localparam int B_START   = 4;
  localparam int B_CTRL    = 3;
  localparam int B_POLL    = 2;
  localparam int B_RSEL_EN = 1;
  localparam int B_RSEL    = 0;
  localparam int B_SMM_EN  = 6;
  localparam int B_SMM     = 5;
  localparam int B_MODEWD  = 0;
  // mode word bits
  localparam int B_NEST    = 4;
  localparam int B_AEOI    = 1;
  localparam int CMD_LSB   = 5;
  localparam logic [DW-1:0] BASE_KEEP = 8'hF8;
  localparam logic [DW-1:0] EMPTY_POLL = DW'(NIN - 1);

  typedef enum logic [1:0] {IS_IDLE, IS_BASE, IS_CASC, IS_MODE} init_st_t;

  typedef enum logic [2:0] {
    OP_EOI_NS     = 3'd0,
    OP_EOI_NS_ROT = 3'd1,
    OP_EOI_SP     = 3'd2,
    OP_EOI_SP_ROT = 3'd3,
    OP_SET_PRI    = 3'd4,
    OP_POLL_CLR   = 3'd5,
    OP_INIT       = 3'd6
  } pcmd_t;
endpackage

// File: rtl/irq_init_seq.sv
module irq_init_seq
  import irq_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          data_we,
  input  logic [DW-1:0] wdata,
  output logic          mask_we,
  output logic [DW-1:0] vec_base,
  output logic          nested,
  output logic          auto_eoi,
  output init_st_t      state
);
  init_st_t      st_n;
  logic          mode_wd, mode_wd_n;
  logic [DW-1:0] base_n;
  logic          nest_n, aeoi_n;

  always_comb begin
    st_n      = state;
    mode_wd_n = mode_wd;
    base_n    = vec_base;
    nest_n    = nested;
    aeoi_n    = auto_eoi;
    if (start) begin
      mode_wd_n = wdata[B_MODEWD];
      st_n      = IS_BASE;
      if (!wdata[B_MODEWD]) begin
        nest_n = 1'b0;
        aeoi_n = 1'b0;
      end
    end else if (data_we) begin
      case (state)
        IS_BASE: begin
          base_n = wdata & BASE_KEEP;
          st_n   = IS_CASC;
        end
        IS_CASC: st_n = mode_wd ? IS_MODE : IS_IDLE;
        IS_MODE: begin
          nest_n = wdata[B_NEST];
          aeoi_n = wdata[B_AEOI];
          st_n   = IS_IDLE;
        end
        default: st_n = IS_IDLE;
      endcase
    end
  end

  assign mask_we = data_we && !start && (state == IS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IS_IDLE;
      mode_wd  <= 1'b0;
      vec_base <= '0;
      nested   <= 1'b0;
      auto_eoi <= 1'b0;
    end else begin
      state    <= st_n;
      mode_wd  <= mode_wd_n;
      vec_base <= base_n;
      nested   <= nest_n;
      auto_eoi <= aeoi_n;
    end
  end

  // R3: the mode-word state is only reachable with the flag recorded
  a_r3_mode_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IS_MODE) |-> mode_wd);
  // R3: the base only moves during the sequence
  a_r3_idle_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IS_IDLE && !start) |=> $stable(vec_base));
endmodule

// File: rtl/irq_op_decode.sv
module irq_op_decode
  import irq_cmd_pkg::*;
(
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic          is_start,
  output logic          is_ctrl,
  output logic          op_valid,
  output pcmd_t         op_code,
  output logic [NW-1:0] op_num,
  output logic          rot_set,
  output logic          rot_clr
);
  logic       is_cmd;
  logic [2:0] cmd;

  assign is_start = wr_en && !addr && wdata[B_START];
  assign is_ctrl  = wr_en && !addr && !wdata[B_START] && wdata[B_CTRL];
  assign is_cmd   = wr_en && !addr && !wdata[B_START] && !wdata[B_CTRL];
  assign cmd      = wdata[CMD_LSB +: 3];

  always_comb begin
    op_valid = 1'b0;
    op_code  = OP_EOI_NS;
    op_num   = '0;
    rot_set  = 1'b0;
    rot_clr  = 1'b0;
    if (is_start) begin
      op_valid = 1'b1;
      op_code  = OP_INIT;
    end else if (is_cmd) begin
      case (cmd)
        3'd0: rot_clr = 1'b1;
        3'd4: rot_set = 1'b1;
        3'd1: begin op_valid = 1'b1; op_code = OP_EOI_NS; end
        3'd5: begin op_valid = 1'b1; op_code = OP_EOI_NS_ROT; end
        3'd3: begin op_valid = 1'b1; op_code = OP_EOI_SP;     op_num = wdata[NW-1:0]; end
        3'd7: begin op_valid = 1'b1; op_code = OP_EOI_SP_ROT; op_num = wdata[NW-1:0]; end
        3'd6: begin op_valid = 1'b1; op_code = OP_SET_PRI;    op_num = wdata[NW-1:0]; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic          addr,
  input  logic          rd_sel,
  input  logic          poll_armed,
  input  logic [DW-1:0] req_bits,
  input  logic [DW-1:0] isv_bits,
  input  logic [DW-1:0] mask,
  input  logic          pend_valid,
  input  logic [NW-1:0] pend_num,
  output logic [DW-1:0] rdata,
  output logic          poll_done,
  output logic          poll_take
);
  logic [DW-1:0] rdata_n;

  assign poll_done = rd_go && poll_armed;
  assign poll_take = poll_done && pend_valid;

  always_comb begin
    rdata_n = rdata;
    if (poll_done)       rdata_n = pend_valid ? DW'(pend_num) : EMPTY_POLL;
    else if (rd_go)      rdata_n = addr ? mask : (rd_sel ? isv_bits : req_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_go) rdata <= rdata_n;
  end

  // R9: an empty poll answers with the highest input number
  a_r9_empty_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_done && !pend_valid) |=> (rdata == EMPTY_POLL));
endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
  import irq_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] req_bits,
  input  logic [DW-1:0] isv_bits,
  input  logic          pend_valid,
  input  logic [NW-1:0] pend_num,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] vec_base_o,
  output logic          nested_o,
  output logic          auto_eoi_o,
  output logic          rot_aeoi_o,
  output logic          spec_mask_o,
  output logic          cmd_stb,
  output logic [2:0]    cmd_op,
  output logic [NW-1:0] cmd_num
);
  logic          is_start, is_ctrl, op_valid, rot_set, rot_clr;
  pcmd_t         op_code;
  logic [NW-1:0] op_num;
  logic          mask_we, poll_done, poll_take, rd_go;
  init_st_t      init_state;

  logic [DW-1:0] mask_q, mask_n;
  logic          smm_q, smm_n, rsel_q, rsel_n, poll_q, poll_n, rot_q, rot_n;
  logic          stb_q, stb_n;
  pcmd_t         op_q, op_n;
  logic [NW-1:0] num_q, num_n;

  assign rd_go = rd_en && !wr_en;

  irq_op_decode u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .is_start(is_start), .is_ctrl(is_ctrl), .op_valid(op_valid),
    .op_code(op_code), .op_num(op_num), .rot_set(rot_set), .rot_clr(rot_clr)
  );

  irq_init_seq u_init (
    .clk(clk), .rst_n(rst_n), .start(is_start), .data_we(wr_en && addr),
    .wdata(wdata), .mask_we(mask_we), .vec_base(vec_base_o),
    .nested(nested_o), .auto_eoi(auto_eoi_o), .state(init_state)
  );

  irq_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .addr(addr), .rd_sel(rsel_q),
    .poll_armed(poll_q), .req_bits(req_bits), .isv_bits(isv_bits),
    .mask(mask_q), .pend_valid(pend_valid), .pend_num(pend_num),
    .rdata(rdata), .poll_done(poll_done), .poll_take(poll_take)
  );

  always_comb begin
    mask_n = mask_q;
    smm_n  = smm_q;
    rsel_n = rsel_q;
    poll_n = poll_q;
    rot_n  = rot_q;
    if (is_start) begin
      mask_n = '0;
      smm_n  = 1'b0;
      rsel_n = 1'b0;
    end else if (mask_we) begin
      mask_n = wdata;
    end else if (is_ctrl) begin
      if (wdata[B_POLL])    poll_n = 1'b1;
      if (wdata[B_RSEL_EN]) rsel_n = wdata[B_RSEL];
      if (wdata[B_SMM_EN])  smm_n  = wdata[B_SMM];
    end
    if (rot_set)      rot_n = 1'b1;
    else if (rot_clr) rot_n = 1'b0;
    if (poll_done)    poll_n = 1'b0;
    stb_n = op_valid || poll_take;
    op_n  = poll_take ? OP_POLL_CLR : op_code;
    num_n = poll_take ? pend_num : op_num;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      smm_q  <= 1'b0;
      rsel_q <= 1'b0;
      poll_q <= 1'b0;
      rot_q  <= 1'b0;
      stb_q  <= 1'b0;
      op_q   <= OP_EOI_NS;
      num_q  <= '0;
    end else begin
      mask_q <= mask_n;
      smm_q  <= smm_n;
      rsel_q <= rsel_n;
      poll_q <= poll_n;
      rot_q  <= rot_n;
      stb_q  <= stb_n;
      if (stb_n) begin
        op_q  <= op_n;
        num_q <= num_n;
      end
    end
  end

  assign mask_o      = mask_q;
  assign spec_mask_o = smm_q;
  assign rot_aeoi_o  = rot_q;
  assign cmd_stb     = stb_q;
  assign cmd_op      = op_q;
  assign cmd_num     = num_q;

  // R2: a start byte clears the mask and signals init
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[B_START]) |=> (mask_o == '0 && cmd_stb && cmd_op == OP_INIT));
  // R4: no write, no mask change
  a_r4_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_o));
  // R9: a poll is consumed by exactly one read
  a_r9_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && poll_q) |=> !poll_q);
  // R10: a colliding read leaves read data alone
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(rdata));
  // R7: a strobe always follows a host access
  a_r7_stb_caused: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(wr_en || rd_en));
endmodule

// File: tb/irq_cmd_seq_test.sv
module irq_cmd_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, addr;
  logic [7:0] wdata, rdata;
  logic [7:0] req_bits, isv_bits;
  logic       pend_valid;
  logic [2:0] pend_num;
  logic [7:0] mask_o, vec_base_o;
  logic       nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o, cmd_stb;
  logic [2:0] cmd_op, cmd_num;

  int total = 0;
  int fails = 0;
  logic       o_stb;
  logic [2:0] o_op, o_num;
  logic [7:0] o_rd;

  always #10 clk = ~clk;

  irq_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .req_bits(req_bits), .isv_bits(isv_bits),
    .pend_valid(pend_valid), .pend_num(pend_num), .mask_o(mask_o),
    .vec_base_o(vec_base_o), .nested_o(nested_o), .auto_eoi_o(auto_eoi_o),
    .rot_aeoi_o(rot_aeoi_o), .spec_mask_o(spec_mask_o), .cmd_stb(cmd_stb),
    .cmd_op(cmd_op), .cmd_num(cmd_num)
  );

  // [31] read, [30] addr, [29:22] data, [21] strobe, [20:18] op,
  // [17:15] num, [14:7] expected read data, [6:0] requirement number
  function automatic logic [31:0] mkv(input logic rd, input logic a, input logic [7:0] d,
                                      input logic s, input logic [2:0] op, input logic [2:0] n,
                                      input logic [7:0] r, input logic [6:0] tag);
    return {rd, a, d, s, op, n, r, tag};
  endfunction

  localparam int NV = 20;
  localparam logic [31:0] VEC [NV] = '{
    mkv(0,0,8'h11,1,3'd6,3'd0,8'h00,7'd2),  // R2 start, mode word expected
    mkv(0,1,8'h4D,0,3'd0,3'd0,8'h00,7'd3),  // R3 base
    mkv(0,1,8'h00,0,3'd0,3'd0,8'h00,7'd3),  // R3 cascade word
    mkv(0,1,8'h12,0,3'd0,3'd0,8'h00,7'd3),  // R3 mode word
    mkv(0,1,8'hF0,0,3'd0,3'd0,8'h00,7'd4),  // R4 mask load
    mkv(1,1,8'h00,0,3'd0,3'd0,8'hF0,7'd8),  // R8 mask read
    mkv(1,0,8'h00,0,3'd0,3'd0,8'hA5,7'd8),  // R8 request read
    mkv(0,0,8'h0B,0,3'd0,3'd0,8'h00,7'd5),  // R5 read-select=1
    mkv(1,0,8'h00,0,3'd0,3'd0,8'h3C,7'd8),  // R8 in-service read
    mkv(0,0,8'h20,1,3'd0,3'd0,8'h00,7'd7),  // R7 non-specific EOI
    mkv(0,0,8'hA0,1,3'd1,3'd0,8'h00,7'd7),  // R7 rotating non-specific
    mkv(0,0,8'h65,1,3'd2,3'd5,8'h00,7'd7),  // R7 specific EOI 5
    mkv(0,0,8'hE6,1,3'd3,3'd6,8'h00,7'd7),  // R7 rotating specific 6
    mkv(0,0,8'hC2,1,3'd4,3'd2,8'h00,7'd7),  // R7 set priority 2
    mkv(0,0,8'h40,0,3'd0,3'd0,8'h00,7'd6),  // R6 command 2 is nothing
    mkv(0,0,8'h0C,0,3'd0,3'd0,8'h00,7'd5),  // R5 arm poll
    mkv(1,0,8'h00,1,3'd5,3'd3,8'h03,7'd9),  // R9 poll hit
    mkv(1,0,8'h00,0,3'd0,3'd0,8'h3C,7'd9),  // R9 poll gone
    mkv(0,0,8'h0A,0,3'd0,3'd0,8'h00,7'd5),  // R5 read-select=0
    mkv(1,0,8'h00,0,3'd0,3'd0,8'hA5,7'd8)   // R8 request again
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(negedge clk);
    o_stb = cmd_stb; o_op = cmd_op; o_num = cmd_num; o_rd = rdata;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_reset_state();
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 base", vec_base_o, 8'h00);
    chk("R1 flags", {2'b0, nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o, cmd_stb, 1'b0}, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
  endtask

  initial begin
    #2_000_000;
    fails++;
    total++;
    $display("FAIL watchdog: got hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] held;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 1'b0; wdata = 8'h00;
    req_bits = 8'hA5; isv_bits = 8'h3C; pend_valid = 1'b1; pend_num = 3'd3;
    do_reset();
    chk_reset_state();   // R1

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string tg;
      v = VEC[i];
      op(!v[31], v[31], v[30], v[29:22]);
      tg = $sformatf("R%0d vec%0d", v[6:0], i);
      chk({tg, " stb"}, {7'b0, o_stb}, {7'b0, v[21]});
      if (v[21]) chk({tg, " op/num"}, {2'b0, o_op, o_num}, {2'b0, v[20:18], v[17:15]});
      if (v[31]) chk({tg, " rdata"}, o_rd, v[14:7]);
    end

    // R3 results of the full sequence
    chk("R3 base", vec_base_o, 8'h48);
    chk("R3 nested/aeoi", {6'b0, nested_o, auto_eoi_o}, 8'h03);
    chk("R4 mask", mask_o, 8'hF0);

    // R6 rotate-on-auto-EOI
    op(1, 0, 0, 8'h80);
    chk("R6 rot set", {7'b0, rot_aeoi_o}, 8'h01);
    op(1, 0, 0, 8'h40);
    chk("R6 cmd2 keeps rot", {7'b0, rot_aeoi_o}, 8'h01);
    chk("R6 cmd2 no stb", {7'b0, o_stb}, 8'h00);
    op(1, 0, 0, 8'h00);
    chk("R6 rot clr", {7'b0, rot_aeoi_o}, 8'h00);

    // R5 special mask with and without enable
    op(1, 0, 0, 8'h68);
    chk("R5 smm set", {7'b0, spec_mask_o}, 8'h01);
    op(1, 0, 0, 8'h28);
    chk("R5 smm enable off", {7'b0, spec_mask_o}, 8'h01);
    op(1, 0, 0, 8'h48);
    chk("R5 smm clr", {7'b0, spec_mask_o}, 8'h00);

    // R10 colliding write and read
    pend_num = 3'd4;
    op(1, 0, 0, 8'h0C);
    held = o_rd;
    op(1, 1, 1, 8'h55);
    chk("R10 rdata held", o_rd, held);
    chk("R10 no poll stb", {7'b0, o_stb}, 8'h00);
    chk("R10 write done", mask_o, 8'h55);
    op(0, 1, 0, 8'h00);
    chk("R10 poll still armed", o_rd, 8'h04);
    chk("R9 poll stb", {o_stb, 1'b0, o_op, o_num}, {1'b1, 1'b0, 3'd5, 3'd4});

    // R9 empty poll
    pend_valid = 1'b0;
    op(1, 0, 0, 8'h0C);
    op(0, 1, 1, 8'h00);
    chk("R9 empty returns 7", o_rd, 8'h07);
    chk("R9 empty no stb", {7'b0, o_stb}, 8'h00);
    op(0, 1, 1, 8'h00);
    chk("R9 disarmed", o_rd, 8'h55);

    // R2/R3 start without mode word
    op(1, 0, 0, 8'h0B);
    op(1, 0, 0, 8'h10);
    chk("R2 mask cleared", mask_o, 8'h00);
    chk("R2 flags cleared", {6'b0, nested_o, auto_eoi_o}, 8'h00);
    chk("R2 init stb", {o_stb, 4'b0, o_op}, {1'b1, 4'b0, 3'd6});
    op(1, 0, 1, 8'h47);
    op(1, 0, 1, 8'hFF);
    op(1, 0, 1, 8'h33);
    chk("R3 no mode word base", vec_base_o, 8'h40);
    chk("R3 third write is mask", mask_o, 8'h33);
    chk("R3 flags stay clear", {6'b0, nested_o, auto_eoi_o}, 8'h00);
    op(0, 1, 0, 8'h00);
    chk("R2 read-select cleared", o_rd, 8'hA5);

    // R1 reset mid-run
    op(1, 0, 0, 8'h11);
    op(1, 0, 1, 8'h88);
    do_reset();
    chk_reset_state();
    op(1, 0, 1, 8'h77);
    chk("R1 idle after reset", mask_o, 8'h77);
    chk("R1 base untouched", vec_base_o, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule